// File: doc/BRIEF.md
# Immediate-Operand Data-Processing Execute Unit

This block is a purely combinational decode-and-execute stage for 32-bit data-processing instructions whose second operand is an immediate. The immediate has already been expanded and rotated before it reaches this block. The block takes:

- a 4-bit operation code,
- the first-operand and destination register indices,
- the set-flags bit,
- the first-operand value,
- the expanded immediate, together with the carry produced while expanding it,
- the current four condition flags.

From these it produces the result, a register-write request for the destination, the updated flags with an update strobe, and an indication that the operation code is not defined.

Two things turn the plain operations into special forms. A destination index of all ones combined with the set-flags bit turns the AND, XOR, add and subtract codes into flag-only test or compare forms, which write no register. A first-operand index of all ones turns the two OR codes into move forms. Each arithmetic code uses its own carry and overflow rule: add, subtract or reverse-subtract. The immediate expander, the register file and the pipeline control lie outside this block.

Top module: `dp_imm_exec`

## Requirements
- R1: Codes 0x0, 0x1, 0x4 give first-operand AND imm, AND NOT imm and XOR imm. Codes 0x2 and 0x3 give first-operand OR imm and OR NOT imm when the first-operand index is not all ones.
- R2: When the first-operand index is all ones (15), code 0x2 gives imm and code 0x3 gives NOT imm.
- R3: When the destination index is 15 and set-flags is 1, codes 0x0, 0x4, 0x8 and 0xD write no register. They still raise the flag-update strobe with flags derived from their result.
- R4: Code 0x8 gives first-operand + imm, and code 0xA gives first-operand + imm + C (flags_in bit 1).
- R5: Code 0xD gives first-operand − imm, code 0xB gives first-operand − imm − (1 − C), and code 0xE gives imm − first-operand.
- R6: The flag word is NZCV with N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. On an update, N is result bit 31 and Z is 1 exactly when the result is zero.
- R7: On an arithmetic update, C is the unsigned carry-out (for subtraction forms, 1 when no borrow occurs) and V is signed overflow.
- R8: On an update from a logical code (0x0–0x4), C equals imm_carry and V keeps its input value.
- R9: With set-flags 0, the update strobe is 0 and flags_out equals flags_in.
- R10: Codes 0x5, 0x6, 0x7, 0x9, 0xC and 0xF raise undef, clear the write request and clear the flag-update strobe.
- R11: Every defined, non-test operation raises the write request, and the write index always equals the destination index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc | input | 4 | Operation code |
| rn_idx | input | 4 | First-operand register index |
| rd_idx | input | 4 | Destination register index |
| set_flags | input | 1 | Flag-update request bit |
| rn_val | input | 32 | First-operand value |
| imm_val | input | 32 | Expanded immediate |
| imm_carry | input | 1 | Carry from immediate expansion |
| flags_in | input | 4 | Current NZCV flags |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Destination write request |
| wr_idx | output | 4 | Destination register index |
| flags_out | output | 4 | Next NZCV flags |
| flags_we | output | 1 | Flag-update strobe |
| undef | output | 1 | Undefined operation code |

## Verification
The hardest cases to reach are the ones where several rules meet at once. Signed overflow and the carry of the subtract-with-carry and reverse-subtract forms have to be hit together with the special index values and each incoming carry. The bench covers this by crossing all sixteen codes with both first-operand indices, both destination indices and both set-flags values, against all sixteen incoming flag words. It runs a fixed operand set chosen to straddle the signed and unsigned boundaries: 0x7FFFFFFF, 0x80000000, all ones, zero and equal pairs.

// File: rtl/dp_imm_pkg.sv
package dp_imm_pkg;

   localparam logic [3:0] OPC_AND = 4'h0;
   localparam logic [3:0] OPC_BIC = 4'h1;
   localparam logic [3:0] OPC_ORR = 4'h2;
   localparam logic [3:0] OPC_ORN = 4'h3;
   localparam logic [3:0] OPC_EOR = 4'h4;
   localparam logic [3:0] OPC_ADD = 4'h8;
   localparam logic [3:0] OPC_ADC = 4'hA;
   localparam logic [3:0] OPC_SBC = 4'hB;
   localparam logic [3:0] OPC_SUB = 4'hD;
   localparam logic [3:0] OPC_RSB = 4'hE;

   localparam int FL_N = 3;
   localparam int FL_Z = 2;
   localparam int FL_C = 1;
   localparam int FL_V = 0;

   typedef enum logic [2:0] {
      LOG_AND, LOG_BIC, LOG_ORR, LOG_ORN, LOG_EOR, LOG_MOV, LOG_MVN
   } dp_logic_e;

   typedef enum logic [2:0] {
      AR_ADD, AR_ADC, AR_SUB, AR_SBC, AR_RSB
   } dp_arith_e;

   typedef struct packed {
      logic      is_arith;
      dp_logic_e lop;
      dp_arith_e aop;
      logic      wr;
      logic      fl;
      logic      undef;
   } dp_ctrl_t;

endpackage

// File: rtl/dp_imm_decode.sv
module dp_imm_decode
   import dp_imm_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [3:0]       opc,
   input  logic [IDX_W-1:0] rn_idx,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             set_flags,
   output dp_ctrl_t         ctrl
);

   localparam logic [IDX_W-1:0] TOP_IDX = {IDX_W{1'b1}};

   logic rd_top;
   logic rn_top;
   logic test_form;

   assign rd_top    = (rd_idx == TOP_IDX);
   assign rn_top    = (rn_idx == TOP_IDX);
   assign test_form = rd_top & set_flags;

   always_comb begin
      ctrl       = '0;
      ctrl.lop   = LOG_AND;
      ctrl.aop   = AR_ADD;
      ctrl.wr    = 1'b1;
      ctrl.fl    = set_flags;
      case (opc)
         OPC_AND: begin
            ctrl.lop = LOG_AND;
            ctrl.wr  = ~test_form;
         end
         OPC_BIC: ctrl.lop = LOG_BIC;
         OPC_ORR: ctrl.lop = rn_top ? LOG_MOV : LOG_ORR;
         OPC_ORN: ctrl.lop = rn_top ? LOG_MVN : LOG_ORN;
         OPC_EOR: begin
            ctrl.lop = LOG_EOR;
            ctrl.wr  = ~test_form;
         end
         OPC_ADD: begin
            ctrl.is_arith = 1'b1;
            ctrl.aop      = AR_ADD;
            ctrl.wr       = ~test_form;
         end
         OPC_ADC: begin
            ctrl.is_arith = 1'b1;
            ctrl.aop      = AR_ADC;
         end
         OPC_SBC: begin
            ctrl.is_arith = 1'b1;
            ctrl.aop      = AR_SBC;
         end
         OPC_SUB: begin
            ctrl.is_arith = 1'b1;
            ctrl.aop      = AR_SUB;
            ctrl.wr       = ~test_form;
         end
         OPC_RSB: begin
            ctrl.is_arith = 1'b1;
            ctrl.aop      = AR_RSB;
         end
         default: begin
            ctrl.undef = 1'b1;
            ctrl.wr    = 1'b0;
            ctrl.fl    = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/dp_imm_logic.sv
module dp_imm_logic
   import dp_imm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  dp_logic_e         lop,
   output logic [DATA_W-1:0] y
);

   always_comb begin
      case (lop)
         LOG_AND: y = a & b;
         LOG_BIC: y = a & ~b;
         LOG_ORR: y = a | b;
         LOG_ORN: y = a | ~b;
         LOG_EOR: y = a ^ b;
         LOG_MOV: y = b;
         LOG_MVN: y = ~b;
         default: y = a & b;
      endcase
   end

endmodule

// File: rtl/dp_imm_arith.sv
module dp_imm_arith
   import dp_imm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  dp_arith_e         aop,
   input  logic              cin,
   output logic [DATA_W-1:0] y,
   output logic              c,
   output logic              v
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] opa;
   logic [DATA_W-1:0] opb;
   logic              ci;
   logic [DATA_W:0]   sum;

   always_comb begin
      opa = a;
      opb = b;
      ci  = 1'b0;
      case (aop)
         AR_ADD: ci = 1'b0;
         AR_ADC: ci = cin;
         AR_SUB: begin
            opb = ~b;
            ci  = 1'b1;
         end
         AR_SBC: begin
            opb = ~b;
            ci  = cin;
         end
         AR_RSB: begin
            opa = ~a;
            ci  = 1'b1;
         end
         default: ci = 1'b0;
      endcase
   end

   assign sum = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, ci};
   assign y   = sum[DATA_W-1:0];
   assign c   = sum[DATA_W];
   assign v   = (opa[MSB] == opb[MSB]) && (y[MSB] != opa[MSB]);

endmodule

// File: rtl/dp_imm_exec.sv
module dp_imm_exec
   import dp_imm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic [3:0]        opc,
   input  logic [IDX_W-1:0]  rn_idx,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic              set_flags,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] imm_val,
   input  logic              imm_carry,
   input  logic [3:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [3:0]        flags_out,
   output logic              flags_we,
   output logic              undef
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dp_imm_exec: DATA_W must be at least 2");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("dp_imm_exec: IDX_W must be at least 1");
      end
   endgenerate

   dp_ctrl_t          ctrl;
   logic [DATA_W-1:0] log_y;
   logic [DATA_W-1:0] ar_y;
   logic              ar_c;
   logic              ar_v;
   logic [3:0]        nzcv_new;

   dp_imm_decode #(.IDX_W(IDX_W)) u_dec (
      .opc       (opc),
      .rn_idx    (rn_idx),
      .rd_idx    (rd_idx),
      .set_flags (set_flags),
      .ctrl      (ctrl)
   );

   dp_imm_logic #(.DATA_W(DATA_W)) u_log (
      .a   (rn_val),
      .b   (imm_val),
      .lop (ctrl.lop),
      .y   (log_y)
   );

   dp_imm_arith #(.DATA_W(DATA_W)) u_ar (
      .a   (rn_val),
      .b   (imm_val),
      .aop (ctrl.aop),
      .cin (flags_in[FL_C]),
      .y   (ar_y),
      .c   (ar_c),
      .v   (ar_v)
   );

   assign result = ctrl.is_arith ? ar_y : log_y;

   always_comb begin
      nzcv_new       = flags_in;
      nzcv_new[FL_N] = result[DATA_W-1];
      nzcv_new[FL_Z] = ~|result;
      nzcv_new[FL_C] = ctrl.is_arith ? ar_c : imm_carry;
      nzcv_new[FL_V] = ctrl.is_arith ? ar_v : flags_in[FL_V];
   end

   assign wr_en     = ctrl.wr;
   assign wr_idx    = rd_idx;
   assign flags_we  = ctrl.fl;
   assign flags_out = ctrl.fl ? nzcv_new : flags_in;
   assign undef     = ctrl.undef;

endmodule

// File: rtl/dp_imm_exec_chk.sv
module dp_imm_exec_chk #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input logic [3:0]        opc,
   input logic [IDX_W-1:0]  rd_idx,
   input logic              set_flags,
   input logic              imm_carry,
   input logic [3:0]        flags_in,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [3:0]        flags_out,
   input logic              flags_we,
   input logic              undef
);

   logic test_code;
   logic logic_code;

   assign test_code  = (opc == 4'h0) || (opc == 4'h4) || (opc == 4'h8) || (opc == 4'hD);
   assign logic_code = (opc <= 4'h4);

   always_comb begin
      // R10
      undef_quiet_chk: assert (!undef || (!wr_en && !flags_we))
         else $error("undefined code wrote state");
      // R9
      no_s_hold_chk: assert (set_flags || (!flags_we && flags_out == flags_in))
         else $error("flags changed without set-flags");
      // R6
      nz_rule_chk: assert (!flags_we ||
                           (flags_out[3] == result[DATA_W-1] && flags_out[2] == (result == '0)))
         else $error("N/Z mismatch");
      // R8
      logic_cv_chk: assert (!(flags_we && logic_code) ||
                            (flags_out[1] == imm_carry && flags_out[0] == flags_in[0]))
         else $error("logical C/V mismatch");
      // R3
      test_no_write_chk: assert (!(test_code && set_flags && rd_idx == {IDX_W{1'b1}}) ||
                                 (!wr_en && flags_we))
         else $error("test form wrote register");
      // R11
      wr_idx_chk: assert (wr_idx == rd_idx)
         else $error("write index differs from destination");
   end

endmodule

bind dp_imm_exec dp_imm_exec_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/dp_imm_exec_tb.sv
`timescale 1ns/1ps
module dp_imm_exec_tb;

   logic        clk = 1'b0;
   logic [3:0]  opc;
   logic [3:0]  rn_idx;
   logic [3:0]  rd_idx;
   logic        set_flags;
   logic [31:0] rn_val;
   logic [31:0] imm_val;
   logic        imm_carry;
   logic [3:0]  flags_in;
   logic [31:0] result;
   logic        wr_en;
   logic [3:0]  wr_idx;
   logic [3:0]  flags_out;
   logic        flags_we;
   logic        undef;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dp_imm_exec u_dut (
      .opc(opc), .rn_idx(rn_idx), .rd_idx(rd_idx), .set_flags(set_flags),
      .rn_val(rn_val), .imm_val(imm_val), .imm_carry(imm_carry),
      .flags_in(flags_in), .result(result), .wr_en(wr_en), .wr_idx(wr_idx),
      .flags_out(flags_out), .flags_we(flags_we), .undef(undef)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s opc=%h rn=%0d rd=%0d s=%0b a=%h b=%h fl=%h: actual %h expected %h",
                  tag, opc, rn_idx, rd_idx, set_flags, rn_val, imm_val, flags_in, act, exp);
      end
   endtask

   function automatic logic [31:0] opnd(input int k, input bit second);
      logic [63:0] p;
      case (k)
         0:  p = {32'h0000_0000, 32'h0000_0000};
         1:  p = {32'hFFFF_FFFF, 32'h0000_0001};
         2:  p = {32'h7FFF_FFFF, 32'h0000_0001};
         3:  p = {32'h8000_0000, 32'h8000_0000};
         4:  p = {32'h0000_0005, 32'h0000_0005};
         5:  p = {32'h0000_0003, 32'h0000_0007};
         6:  p = {32'h8000_0000, 32'h0000_0001};
         7:  p = {32'h1234_5678, 32'h0F0F_0F0F};
         8:  p = {32'h0000_0000, 32'hFFFF_FFFF};
         9:  p = {32'h7FFF_FFFF, 32'hFFFF_FFFF};
         10: p = {32'hDEAD_BEEF, 32'hDEAD_BEEF};
         default: p = {32'h0000_0001, 32'h0000_0000};
      endcase
      return second ? p[31:0] : p[63:32];
   endfunction

   task automatic check_vector();
      logic [31:0] r;
      logic        c;
      logic        v;
      logic        defd;
      logic        arith;
      logic        tst;
      logic [3:0]  fexp;
      longint      sa, sb, ss;
      logic [32:0] ua, ub;
      logic        cin;
      string       rtag;
      cin   = flags_in[1];
      sa    = longint'($signed(rn_val));
      sb    = longint'($signed(imm_val));
      ua    = {1'b0, rn_val};
      ub    = {1'b0, imm_val};
      defd  = !(opc inside {4'h5, 4'h6, 4'h7, 4'h9, 4'hC, 4'hF});
      arith = opc inside {4'h8, 4'hA, 4'hB, 4'hD, 4'hE};
      tst   = (opc inside {4'h0, 4'h4, 4'h8, 4'hD}) && rd_idx == 4'hF && set_flags;
      c     = imm_carry;
      v     = flags_in[0];
      ss    = 0;
      r     = '0;
      rtag  = "R1";
      case (opc)
         4'h0: r = rn_val & imm_val;
         4'h1: r = rn_val & ~imm_val;
         4'h2: begin r = (rn_idx == 4'hF) ? imm_val : (rn_val | imm_val);
                  if (rn_idx == 4'hF) rtag = "R2"; end
         4'h3: begin r = (rn_idx == 4'hF) ? ~imm_val : (rn_val | ~imm_val);
                  if (rn_idx == 4'hF) rtag = "R2"; end
         4'h4: r = rn_val ^ imm_val;
         4'h8: begin ss = sa + sb; r = rn_val + imm_val;
                  c = (ua + ub) > 33'hFFFF_FFFF; rtag = "R4"; end
         4'hA: begin ss = sa + sb + longint'(cin); r = rn_val + imm_val + 32'(cin);
                  c = (ua + ub + 33'(cin)) > 33'hFFFF_FFFF; rtag = "R4"; end
         4'hB: begin ss = sa - sb - longint'(!cin); r = rn_val - imm_val - 32'(!cin);
                  c = ua >= (ub + 33'(!cin)); rtag = "R5"; end
         4'hD: begin ss = sa - sb; r = rn_val - imm_val; c = ua >= ub; rtag = "R5"; end
         4'hE: begin ss = sb - sa; r = imm_val - rn_val; c = ub >= ua; rtag = "R5"; end
         default: r = '0;
      endcase
      if (arith) v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);

      chk(undef == !defd, "R10 undef", {31'b0, undef}, {31'b0, !defd});
      chk(wr_en == (defd && !tst), tst ? "R3 wr_en" : (defd ? "R11 wr_en" : "R10 wr_en"),
          {31'b0, wr_en}, {31'b0, defd && !tst});
      chk(wr_idx == rd_idx, "R11 wr_idx", {28'b0, wr_idx}, {28'b0, rd_idx});
      chk(flags_we == (defd && set_flags), set_flags ? (defd ? "R3 flags_we" : "R10 flags_we")
                                                     : "R9 flags_we",
          {31'b0, flags_we}, {31'b0, defd && set_flags});
      if (defd) begin
         chk(result == r, rtag, result, r);
         fexp = set_flags ? {r[31], r == 32'h0, c, v} : flags_in;
         chk(flags_out == fexp, !set_flags ? "R9 flags" : (arith ? "R7 flags" : "R8 flags"),
             {28'b0, flags_out}, {28'b0, fexp});
         if (set_flags)
            chk(flags_out[3:2] == {r[31], r == 32'h0}, "R6 NZ",
                {30'b0, flags_out[3:2]}, {30'b0, r[31], r == 32'h0});
      end else begin
         chk(flags_out == flags_in, "R10 flags", {28'b0, flags_out}, {28'b0, flags_in});
      end
   endtask

   initial begin
      opc = '0; rn_idx = '0; rd_idx = '0; set_flags = 1'b0;
      rn_val = '0; imm_val = '0; imm_carry = 1'b0; flags_in = 4'h0;
      @(negedge clk);
      // idle state with all inputs zero (R1): AND of zeros, write requested, no flag update
      chk(result == 32'h0 && wr_en && !flags_we && !undef, "R1 idle",
          {28'b0, wr_en, flags_we, undef, |result}, 32'h8);
      for (int o = 0; o < 16; o++)
         for (int ni = 0; ni < 2; ni++)
            for (int di = 0; di < 2; di++)
               for (int s = 0; s < 2; s++)
                  for (int k = 0; k < 12; k++)
                     for (int f = 0; f < 16; f++) begin
                        @(posedge clk);
                        opc       = 4'(o);
                        rn_idx    = ni ? 4'hF : 4'h2;
                        rd_idx    = di ? 4'hF : 4'h3;
                        set_flags = 1'(s);
                        rn_val    = opnd(k, 1'b0);
                        imm_val   = opnd(k, 1'b1);
                        flags_in  = 4'(f);
                        imm_carry = 1'(f >> 2) ^ 1'(k);
                        @(negedge clk);
                        check_vector();
                     end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule